// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line Error Flags

This block is the receive half of an asynchronous serial port. A free-running enable pulse at sixteen times the bit rate comes from outside. On each pulse the block looks at the synchronized receive line. A falling level starts a frame. The block confirms the start bit at mid-bit, then collects the data bits least significant bit first, followed by an optional parity bit and one stop bit. Each bit's value is the majority of three samples taken around its centre.

When the stop bit has been judged, the assembled word moves into a one-entry receive buffer and the buffer-full flag rises. Four error flags travel with the buffered word: framing, parity, noise and overrun. A single interrupt line combines every flag with its own enable. One read pulse empties the buffer and clears all flags. When flow control is switched on, a request-to-send output (active low) tells the far end whether the buffer can take another word.

Top module: `rx_frame_engine`

## Requirements
- R1: A start candidate whose majority value at samples 7, 8 and 9 is 1 is dropped. The receiver returns to idle, and no word and no flag reach the buffer.
- R2: The data bits are placed into the word least significant bit first. The stop-bit judgement copies the word to `rxData` and sets `rxFull` to 1.
- R3: Each bit (start, data, parity, stop) takes the majority of its samples 7, 8 and 9 of 16. A single disagreeing sample does not change the received value.
- R4: If the three samples of any bit in a frame are not all equal, `noiseErr` is 1 for the buffered word.
- R5: A stop bit whose majority value is 0 sets `frameErr` for the buffered word.
- R6: With `parityEn`=1, one parity bit follows the data bits. The XOR of the data bits and the parity bit must equal `parityOdd` (0 = even, 1 = odd). On a mismatch, `parityErr` is 1 for the buffered word. With `parityEn`=0, no parity bit is expected and `parityErr` stays 0.
- R7: If a frame completes while `rxFull` is 1 and no read happens in that cycle, `overrunErr` becomes 1. In that case `rxData`, `rxFull` and the other flags keep their values. A read in the same cycle as completion loads the new word and does not flag an overrun.
- R8: A one-cycle `rdEn` pulse clears `rxFull` and all four error flags.
- R9: `irq` is 1 exactly when at least one flag is set whose enable input is 1. The pairs are `rxFull`/`ieFull`, `frameErr`/`ieFrame`, `parityErr`/`ieParity`, `noiseErr`/`ieNoise` and `overrunErr`/`ieOverrun`.
- R10: With `flowCtlEn`=1, `rtsN` is 0 while the buffer is empty and 1 while it is full. With `flowCtlEn`=0, `rtsN` stays 0.
- R11: After reset, `rxFull`, all error flags and `irq` are 0, and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxIn | input | 1 | Serial receive line, idle high |
| sampleTick | input | 1 | One-cycle enable pulse at 16x the bit rate |
| parityEn | input | 1 | Expect a parity bit after the data bits |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| flowCtlEn | input | 1 | Drive `rtsN` from the buffer state |
| ieFull | input | 1 | Interrupt enable for `rxFull` |
| ieFrame | input | 1 | Interrupt enable for `frameErr` |
| ieParity | input | 1 | Interrupt enable for `parityErr` |
| ieNoise | input | 1 | Interrupt enable for `noiseErr` |
| ieOverrun | input | 1 | Interrupt enable for `overrunErr` |
| rdEn | input | 1 | Read pulse; empties the buffer |
| rxData | output | DATA_W | Buffered word |
| rxFull | output | 1 | Buffer holds an unread word |
| frameErr | output | 1 | Stop bit of the buffered word was 0 |
| parityErr | output | 1 | Parity mismatch on the buffered word |
| noiseErr | output | 1 | Sample disagreement in the buffered frame |
| overrunErr | output | 1 | A frame was lost because the buffer was full |
| irq | output | 1 | Combined interrupt request |
| rtsN | output | 1 | Request to send, active low |

## Verification
If the sample counter or the bit counter drifts, the fault shows in the very next frame. The word at `rxData` then appears shifted by a bit, or `frameErr` rises on a clean line. Noise injected on one sample per bit is aimed at the middle of the vote window. A majority vote placed on the wrong samples therefore either lets a bad sample flip the data or loses the noise flag on that same frame. Buffer and flag faults show within one read cycle. A stuck `rxFull` produces a false overrun on the next word. A read that clears nothing leaves `irq` and `rtsN` wrong at once.

// File: rtl/rxfe_pkg.sv
package rxfe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_t;

  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic grabEarly;   // sample before centre
    logic grabMid;     // centre sample
    logic evalStart;   // third sample of start bit: judge
    logic evalData;    // third sample of a data bit: shift
    logic evalPar;     // third sample of parity bit
    logic evalStop;    // third sample of stop bit: commit
  } rxStrobe_t;

endpackage

// File: rtl/rxfe_ctrl.sv
module rxfe_ctrl
  import rxfe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      rxS,
  input  logic      parityEn,
  input  logic      majBit,
  output rxStrobe_t stb
);

  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] SMP_EARLY = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] SMP_MID   = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] SMP_LATE  = CNT_W'(OVS / 2 + 1);
  localparam logic [CNT_W-1:0] SMP_LAST  = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

  rxState_t         state;
  logic [CNT_W-1:0] smpCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             busyTick;
  logic             judge;

  assign busyTick = tick && (state != ST_IDLE);
  assign judge    = busyTick && (smpCnt == SMP_LATE);

  always_comb begin
    stb           = '0;
    stb.grabEarly = busyTick && (smpCnt == SMP_EARLY);
    stb.grabMid   = busyTick && (smpCnt == SMP_MID);
    stb.evalStart = judge && (state == ST_START);
    stb.evalData  = judge && (state == ST_DATA);
    stb.evalPar   = judge && (state == ST_PAR);
    stb.evalStop  = judge && (state == ST_STOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      smpCnt <= '0;
      bitCnt <= '0;
    end else if (state == ST_IDLE) begin
      if (tick && !rxS) begin
        state  <= ST_START;
        smpCnt <= CNT_W'(1);
      end
    end else if (tick) begin
      smpCnt <= (smpCnt == SMP_LAST) ? '0 : smpCnt + 1'b1;
      unique case (state)
        ST_START: begin
          if (judge && majBit) begin
            state <= ST_IDLE;
          end else if (smpCnt == SMP_LAST) begin
            state  <= ST_DATA;
            bitCnt <= '0;
          end
        end
        ST_DATA: begin
          if (smpCnt == SMP_LAST) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == BIT_LAST) state <= parityEn ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          if (smpCnt == SMP_LAST) state <= ST_STOP;
        end
        ST_STOP: begin
          if (judge) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: a high start majority sends the receiver back to idle
  a_r1_glitch_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evalStart && majBit) |=> (state == ST_IDLE));

  // R3: the vote samples and judgements never coincide
  a_r3_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

endmodule

// File: rtl/rxfe_dpath.sv
module rxfe_dpath
  import rxfe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxS,
  input  rxStrobe_t         stb,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              rdEn,
  output logic              majBit,
  output logic [DATA_W-1:0] bufData,
  output logic              bufFull,
  output logic              frmFlag,
  output logic              parFlag,
  output logic              noiseFlag,
  output logic              ovrFlag
);

  logic              smpEarly, smpMid;
  logic              disagree;
  logic              noiseAcc;
  logic              parAcc;
  logic [DATA_W-1:0] shiftReg;
  logic              anyEval;
  logic              commit;

  assign majBit   = (smpEarly & smpMid) | (smpEarly & rxS) | (smpMid & rxS);
  assign disagree = !((smpEarly == smpMid) && (smpMid == rxS));
  assign anyEval  = stb.evalStart | stb.evalData | stb.evalPar | stb.evalStop;
  assign commit   = stb.evalStop;

  // vote samples and per-frame accumulators
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpEarly <= 1'b1;
      smpMid   <= 1'b1;
      noiseAcc <= 1'b0;
      parAcc   <= 1'b0;
      shiftReg <= '0;
    end else begin
      if (stb.grabEarly) smpEarly <= rxS;
      if (stb.grabMid)   smpMid   <= rxS;
      if (stb.evalStart) begin
        noiseAcc <= disagree;
        parAcc   <= 1'b0;
      end else if (anyEval) begin
        noiseAcc <= noiseAcc | disagree;
      end
      if (stb.evalData) begin
        shiftReg <= {majBit, shiftReg[DATA_W-1:1]};
        parAcc   <= parAcc ^ majBit;
      end
      if (stb.evalPar) parAcc <= parAcc ^ majBit;
    end
  end

  // receive buffer and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufData   <= '0;
      bufFull   <= 1'b0;
      frmFlag   <= 1'b0;
      parFlag   <= 1'b0;
      noiseFlag <= 1'b0;
      ovrFlag   <= 1'b0;
    end else if (commit) begin
      if (bufFull && !rdEn) begin
        ovrFlag <= 1'b1;
      end else begin
        bufData   <= shiftReg;
        bufFull   <= 1'b1;
        frmFlag   <= !majBit;
        parFlag   <= parityEn && (parAcc != parityOdd);
        noiseFlag <= noiseAcc | disagree;
        ovrFlag   <= 1'b0;
      end
    end else if (rdEn) begin
      bufFull   <= 1'b0;
      frmFlag   <= 1'b0;
      parFlag   <= 1'b0;
      noiseFlag <= 1'b0;
      ovrFlag   <= 1'b0;
    end
  end

  // R2: a completed frame leaves the buffer full
  a_r2_full_after_commit: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> bufFull);

  // R7: an unread buffer keeps its word when another frame lands
  a_r7_keep_old: assert property (@(posedge clk) disable iff (!rstN)
    (commit && bufFull && !rdEn) |=> ($stable(bufData) && ovrFlag));

  // R8: a read with no frame completing empties the buffer
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !commit) |=> (!bufFull && !ovrFlag && !frmFlag));

endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import rxfe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic              sampleTick,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              flowCtlEn,
  input  logic              ieFull,
  input  logic              ieFrame,
  input  logic              ieParity,
  input  logic              ieNoise,
  input  logic              ieOverrun,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              frameErr,
  output logic              parityErr,
  output logic              noiseErr,
  output logic              overrunErr,
  output logic              irq,
  output logic              rtsN
);

  logic [1:0] syncPipe;
  logic       rxS;
  logic       majBit;
  rxStrobe_t  stb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= 2'b11;
    else       syncPipe <= {syncPipe[0], rxIn};
  end
  assign rxS = syncPipe[1];

  rxfe_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (sampleTick),
    .rxS      (rxS),
    .parityEn (parityEn),
    .majBit   (majBit),
    .stb      (stb)
  );

  rxfe_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .rxS       (rxS),
    .stb       (stb),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .rdEn      (rdEn),
    .majBit    (majBit),
    .bufData   (rxData),
    .bufFull   (rxFull),
    .frmFlag   (frameErr),
    .parFlag   (parityErr),
    .noiseFlag (noiseErr),
    .ovrFlag   (overrunErr)
  );

  assign irq  = (rxFull & ieFull) | (frameErr & ieFrame) | (parityErr & ieParity)
              | (noiseErr & ieNoise) | (overrunErr & ieOverrun);
  assign rtsN = flowCtlEn & rxFull;

endmodule

// File: tb/sim_rx_frame_engine.sv
module sim_rx_frame_engine;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic [7:0] d;
    logic       f;
    logic       p;
    logic       n;
  } exp_t;

  logic       clk = 0;
  logic       rstN = 0;
  logic       rxIn = 1;
  logic       sampleTick = 0;
  logic       parityEn = 0, parityOdd = 0, flowCtlEn = 1;
  logic       ieFull = 1, ieFrame = 0, ieParity = 0, ieNoise = 0, ieOverrun = 0;
  logic       rdEn = 0;
  logic [7:0] rxData;
  logic       rxFull, frameErr, parityErr, noiseErr, overrunErr, irq, rtsN;

  int   total = 0;
  int   bad = 0;
  bit   autoRead = 1;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) sampleTick <= ~sampleTick;

  rx_frame_engine u0 (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .sampleTick(sampleTick),
    .parityEn(parityEn), .parityOdd(parityOdd), .flowCtlEn(flowCtlEn),
    .ieFull(ieFull), .ieFrame(ieFrame), .ieParity(ieParity), .ieNoise(ieNoise),
    .ieOverrun(ieOverrun), .rdEn(rdEn), .rxData(rxData), .rxFull(rxFull),
    .frameErr(frameErr), .parityErr(parityErr), .noiseErr(noiseErr),
    .overrunErr(overrunErr), .irq(irq), .rtsN(rtsN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one sample = two clocks (tick every other clock)
  task automatic hold(input logic v, input int samples);
    for (int s = 0; s < samples; s++) begin
      rxIn = v;
      repeat (2) @(negedge clk);
    end
  endtask

  // noiseIdx: bit index (0 = start) whose sample 8 is inverted, -1 for none
  task automatic sendFrame(input logic [7:0] d, input logic stopV, input int noiseIdx,
                           input logic flipPar, input bit push);
    logic bits[11];
    int   n = 0;
    bits[n++] = 1'b0;
    for (int i = 0; i < 8; i++) bits[n++] = d[i];
    if (parityEn) bits[n++] = (^d) ^ parityOdd ^ flipPar;
    bits[n++] = stopV;
    if (push) q.push_back('{d: d, f: !stopV, p: parityEn & flipPar, n: (noiseIdx >= 0)});
    for (int b = 0; b < n; b++)
      for (int s = 0; s < 16; s++) begin
        rxIn = bits[b] ^ ((b == noiseIdx) && (s == 8));
        repeat (2) @(negedge clk);
      end
    hold(1'b1, 20);
  endtask

  task automatic pulseRead();
    rdEn = 1;
    @(negedge clk);
    rdEn = 0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (autoRead && rxFull && !rdEn) begin
        exp_t e;
        logic expIrq;
        if (q.size() == 0) begin
          chk("R1 unexpected word", 32'(rxData), 32'hFFFF);
        end else begin
          e = q.pop_front();
          chk("R2/R3 data", 32'(rxData), 32'(e.d));
          chk("R5/R6/R4 flags", {29'd0, frameErr, parityErr, noiseErr}, {29'd0, e.f, e.p, e.n});
          chk("R7 no overrun", 32'(overrunErr), 32'd0);
          expIrq = ieFull | (ieFrame & e.f) | (ieParity & e.p) | (ieNoise & e.n);
          chk("R9 irq", 32'(irq), 32'(expIrq));
          chk("R10 rts full", 32'(rtsN), 32'(flowCtlEn));
        end
        rdEn = 1;
        @(negedge clk);
        rdEn = 0;
        chk("R8 read clears", {30'd0, rxFull, frameErr | parityErr | noiseErr}, 32'd0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 full", 32'(rxFull), 0);
    chk("R11 flags", {28'd0, frameErr, parityErr, noiseErr, overrunErr}, 0);
    chk("R11 irq", 32'(irq), 0);
    rstN = 1;
    hold(1'b1, 4);
    chk("R10 rts empty", 32'(rtsN), 0);

    // R2: clean frames, parity off
    sendFrame(8'hA5, 1, -1, 0, 1);
    sendFrame(8'h01, 1, -1, 0, 1);
    sendFrame(8'h80, 1, -1, 0, 1);
    // R3/R4: noise on a data bit and on the start bit
    sendFrame(8'h3C, 1, 3, 0, 1);
    sendFrame(8'h81, 1, 0, 0, 1);
    // R5: stop bit low
    sendFrame(8'h5A, 0, -1, 0, 1);
    // R6: even then odd parity, good and bad
    parityEn = 1;
    sendFrame(8'h07, 1, -1, 0, 1);
    sendFrame(8'h07, 1, -1, 1, 1);
    parityOdd = 1;
    sendFrame(8'hC3, 1, -1, 0, 1);
    sendFrame(8'hC3, 1, -1, 1, 1);
    parityEn = 0;
    parityOdd = 0;

    // R1: short low pulse is dropped
    autoRead = 0;
    hold(1'b0, 4);
    hold(1'b1, 40);
    chk("R1 glitch ignored", 32'(rxFull), 0);
    autoRead = 1;
    sendFrame(8'h66, 1, -1, 0, 1);

    // R9: irq from noise only
    ieFull = 0;
    ieNoise = 1;
    sendFrame(8'h12, 1, -1, 0, 1);
    sendFrame(8'h34, 1, 5, 0, 1);
    ieFull = 1;
    ieNoise = 0;

    // R7: overrun keeps the first word
    autoRead = 0;
    sendFrame(8'h11, 1, -1, 0, 0);
    sendFrame(8'h22, 1, -1, 0, 0);
    chk("R7 old data", 32'(rxData), 32'h11);
    chk("R7 overrun", 32'(overrunErr), 1);
    chk("R7 full", 32'(rxFull), 1);
    chk("R10 rts full", 32'(rtsN), 1);
    ieFull = 0;
    ieOverrun = 1;
    chk("R9 irq overrun", 32'(irq), 1);
    ieOverrun = 0;
    ieFull = 1;
    pulseRead();
    chk("R8 full clear", 32'(rxFull), 0);
    chk("R8 overrun clear", 32'(overrunErr), 0);
    chk("R10 rts empty", 32'(rtsN), 0);

    // R10: flow control off keeps rts low while full
    flowCtlEn = 0;
    sendFrame(8'h77, 1, -1, 0, 0);
    chk("R10 full no flow", 32'(rxFull), 1);
    chk("R10 rts off", 32'(rtsN), 0);
    pulseRead();
    flowCtlEn = 1;
    autoRead = 1;

    repeat (20) @(negedge clk);
    chk("R2 scoreboard drained", 32'(q.size()), 0);
    finishRun();
  end

endmodule